// File: doc/BRIEF.md
# Dataway Flash Programming Command Decoder

This block sits between a crate dataway and a byte-wide programmable flash that holds configuration images. The host issues function-19 writes to this station. The subaddress selects one of a fixed set of actions: entering or leaving programming mode, clearing the data address counter, presenting the counter to the flash, writing a byte to the flash, choosing which half of the flash is active, and driving the program pin of the logic that boots from the flash.

All dataway signals are active low, the data byte included. The host therefore writes the complement of the byte it wants stored. Byte writes go either to the two unlock addresses 5555h and 2AAAh, or to the data address counter. This lets the host frame each 256-byte sector with the unlock sequence AAh→5555h, 55h→2AAAh, A0h→5555h. The block also sets the direction of the shared read/write data transceivers from the F8 and F16 function bits, and answers Q and X for the subaddresses it recognises.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `flash_we_n` and `boot_pin_n` are high, `flash_addr` is 0 (sector bit 0, latched address 0), the data counter is 0 and programming mode is off.
- R2: A command executes once, on the first clock edge at which `strobe1_n` is seen low, and only when `station_n` is low and `func_n` equals the complement of 19 (5'b01100). Holding the strobe low longer does not repeat the command, and a wrong station or function has no effect.
- R3: `x_n` and `q_n` are low while the station is addressed with function 19 and `sub_n` is the complement of one of 0–7, 12, 14 or 15. They are high otherwise.
- R4: `dir_to_logic` is 0 (read, logic to dataway) only when `func_n[3]` (F8) and `func_n[4]` (F16) are both high. It is 1 in every other case.
- R5: Subaddress 4 turns programming mode on and subaddress 5 turns it off.
- R6: A byte write (subaddress 0, 1, 2, 3 or 6) in programming mode drives `flash_we_n` low for exactly one cycle, in the cycle after the executing edge. During that cycle `flash_data` is the complement of `wdata_n` and `flash_addr` is the previously latched address.
- R7: After its write, subaddress 0 latches 5555h and subaddress 1 latches 2AAAh as the low 18 address bits.
- R8: After its write, subaddress 2 increments the counter and latches the new value. Subaddress 3 latches the counter unchanged. Subaddress 6 increments the counter and keeps the latched address.
- R9: Subaddress 7 clears the counter without changing the latched address. Subaddress 12 latches the counter as the flash address.
- R10: Subaddress 14 loads the true data bit 0 into `flash_addr[18]`: 0 selects the lower half of the flash and 1 the upper half.
- R11: Subaddress 15 with true data bit 0 equal to 1 drives `boot_pin_n` low. With bit 0 equal to 0 it drives the pin high.
- R12: Outside programming mode a byte write produces no write strobe and changes neither the latched address nor the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| station_n | input | 1 | Station-select line, active low |
| strobe1_n | input | 1 | First dataway strobe, active low |
| func_n | input | 5 | Function code, active low, bit 0 = F1 … bit 4 = F16 |
| sub_n | input | 4 | Subaddress, active low |
| wdata_n | input | 8 | Write data byte, active low |
| dir_to_logic | output | 1 | Transceiver direction: 1 = dataway to logic, 0 = logic to dataway |
| q_n | output | 1 | Q response, active low |
| x_n | output | 1 | X (command accepted), active low |
| flash_addr | output | 19 | Flash address: sector bit on top, latched address below |
| flash_data | output | 8 | Byte presented to the flash (true polarity) |
| flash_we_n | output | 1 | Flash write strobe, active low |
| boot_pin_n | output | 1 | Program pin of the booting logic, low holds it in reset |

## Verification
On every cycle the assertions check four things: a write strobe never lasts beyond one cycle, a byte write outside programming mode never produces a strobe, an unlock write always leaves the matching special address latched, and the program pin and X response change only under a matching command or addressed station. The exact order of address updates across the counter commands, the data complement, the sector bit on top of the address and the single execution under a long strobe are shown only by the bench's command sequences. The bench compares each of these against addresses it predicts cycle by cycle.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam logic [3:0] SUB_SPEC0     = 4'd0;
  localparam logic [3:0] SUB_SPEC1     = 4'd1;
  localparam logic [3:0] SUB_WR_INC    = 4'd2;
  localparam logic [3:0] SUB_WR_LATCH  = 4'd3;
  localparam logic [3:0] SUB_PROG_ON   = 4'd4;
  localparam logic [3:0] SUB_PROG_OFF  = 4'd5;
  localparam logic [3:0] SUB_WR_LAST   = 4'd6;
  localparam logic [3:0] SUB_CNT_CLR   = 4'd7;
  localparam logic [3:0] SUB_CNT_SHOW  = 4'd12;
  localparam logic [3:0] SUB_SECTOR    = 4'd14;
  localparam logic [3:0] SUB_BOOT_PIN  = 4'd15;

  // Address action that follows a flash byte write
  typedef enum logic [2:0] {
    OP_NONE,
    OP_SPEC0,
    OP_SPEC1,
    OP_INC_LATCH,
    OP_LATCH,
    OP_INC
  } wr_op_e;

  typedef struct packed {
    logic   known;
    logic   is_write;
    wr_op_e op;
    logic   prog_on;
    logic   prog_off;
    logic   cnt_clr;
    logic   cnt_show;
    logic   sector_set;
    logic   pin_set;
  } cmd_t;

endpackage

// File: rtl/fcd_decode.sv
module fcd_decode
  import fcd_pkg::*;
#(
  parameter int FUNC_W    = 5,
  parameter int SUB_W     = 4,
  parameter int FUNC_CODE = 19
) (
  input  logic              station_n,
  input  logic [FUNC_W-1:0] func_n,
  input  logic [SUB_W-1:0]  sub_n,
  output cmd_t              cmd,
  output logic              addressed,
  output logic              dir_to_logic
);

  localparam logic [FUNC_W-1:0] FCODE = FUNC_W'(FUNC_CODE);

  logic [SUB_W-1:0]  sub_t;
  logic [FUNC_W-1:0] func_t;

  assign sub_t  = ~sub_n;
  assign func_t = ~func_n;

  assign addressed = !station_n && (func_t == FCODE);

  // Read direction only when F8 and F16 both read false (high)
  assign dir_to_logic = !(func_n[3] && func_n[4]);

  always_comb begin
    cmd          = '0;
    cmd.op       = OP_NONE;
    cmd.known    = 1'b1;
    case (4'(sub_t))
      SUB_SPEC0:    begin cmd.is_write = 1'b1; cmd.op = OP_SPEC0;     end
      SUB_SPEC1:    begin cmd.is_write = 1'b1; cmd.op = OP_SPEC1;     end
      SUB_WR_INC:   begin cmd.is_write = 1'b1; cmd.op = OP_INC_LATCH; end
      SUB_WR_LATCH: begin cmd.is_write = 1'b1; cmd.op = OP_LATCH;     end
      SUB_WR_LAST:  begin cmd.is_write = 1'b1; cmd.op = OP_INC;       end
      SUB_PROG_ON:  cmd.prog_on    = 1'b1;
      SUB_PROG_OFF: cmd.prog_off   = 1'b1;
      SUB_CNT_CLR:  cmd.cnt_clr    = 1'b1;
      SUB_CNT_SHOW: cmd.cnt_show   = 1'b1;
      SUB_SECTOR:   cmd.sector_set = 1'b1;
      SUB_BOOT_PIN: cmd.pin_set    = 1'b1;
      default:      cmd.known      = 1'b0;
    endcase
  end

endmodule

// File: rtl/fcd_ctrl_regs.sv
module fcd_ctrl_regs
  import fcd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  cmd_t cmd,
  input  logic data_bit0,
  output logic prog_mode,
  output logic sector,
  output logic boot_pin_n
);

  logic mode_q, mode_d;
  logic sect_q, sect_d;
  logic pin_q,  pin_d;

  always_comb begin
    mode_d = mode_q;
    sect_d = sect_q;
    pin_d  = pin_q;
    if (fire) begin
      if (cmd.prog_on)    mode_d = 1'b1;
      if (cmd.prog_off)   mode_d = 1'b0;
      if (cmd.sector_set) sect_d = data_bit0;
      if (cmd.pin_set)    pin_d  = !data_bit0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      sect_q <= 1'b0;
      pin_q  <= 1'b1;
    end else begin
      mode_q <= mode_d;
      sect_q <= sect_d;
      pin_q  <= pin_d;
    end
  end

  assign prog_mode  = mode_q;
  assign sector     = sect_q;
  assign boot_pin_n = pin_q;

  // R11
  pin_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_q) |-> $past(fire && cmd.pin_set));

  // R10
  sector_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sect_q) |-> $past(fire && cmd.sector_set));

endmodule

// File: rtl/fcd_addr_path.sv
module fcd_addr_path
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int SPEC0  = 'h5555,
  parameter int SPEC1  = 'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  cmd_t              cmd,
  input  logic              prog_mode,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-2:0] addr_lo,
  output logic [DATA_W-1:0] flash_data,
  output logic              flash_we_n
);

  localparam int LO_W = ADDR_W - 1;
  localparam logic [LO_W-1:0] SPEC0_A = LO_W'(SPEC0);
  localparam logic [LO_W-1:0] SPEC1_A = LO_W'(SPEC1);

  logic [LO_W-1:0]   cnt_q, cnt_d;
  logic [LO_W-1:0]   lat_q, lat_d;
  logic              wr_q, wr_d;
  wr_op_e            op_q, op_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic [LO_W-1:0]   cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    lat_d = lat_q;
    wr_d  = 1'b0;
    op_d  = op_q;
    dat_d = dat_q;
    // Address follow-up of the write that is on the flash this cycle
    if (wr_q) begin
      case (op_q)
        OP_SPEC0:     lat_d = SPEC0_A;
        OP_SPEC1:     lat_d = SPEC1_A;
        OP_INC_LATCH: begin cnt_d = cnt_inc; lat_d = cnt_inc; end
        OP_LATCH:     lat_d = cnt_q;
        OP_INC:       cnt_d = cnt_inc;
        default:      ;
      endcase
    end
    if (fire) begin
      if (cmd.is_write && prog_mode) begin
        wr_d  = 1'b1;
        op_d  = cmd.op;
        dat_d = data_in;
      end
      if (cmd.cnt_clr)  cnt_d = '0;
      if (cmd.cnt_show) lat_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= '0;
      wr_q  <= 1'b0;
      op_q  <= OP_NONE;
      dat_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lat_q <= lat_d;
      wr_q  <= wr_d;
      op_q  <= op_d;
      dat_q <= dat_d;
    end
  end

  assign addr_lo    = lat_q;
  assign flash_data = dat_q;
  assign flash_we_n = !wr_q;

  // R6
  we_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_we_n |=> flash_we_n);

  // R12
  we_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd.is_write && !prog_mode) |=> flash_we_n);

  // R7
  spec0_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_we_n && op_q == OP_SPEC0) |=> (addr_lo == SPEC0_A));

  // R7
  spec1_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_we_n && op_q == OP_SPEC1) |=> (addr_lo == SPEC1_A));

  // R8
  last_keeps_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_we_n && op_q == OP_INC) |=> $stable(addr_lo));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int FUNC_W    = 5,
  parameter int SUB_W     = 4,
  parameter int FUNC_CODE = 19,
  parameter int SPEC0     = 'h5555,
  parameter int SPEC1     = 'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              station_n,
  input  logic              strobe1_n,
  input  logic [FUNC_W-1:0] func_n,
  input  logic [SUB_W-1:0]  sub_n,
  input  logic [DATA_W-1:0] wdata_n,
  output logic              dir_to_logic,
  output logic              q_n,
  output logic              x_n,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [DATA_W-1:0] flash_data,
  output logic              flash_we_n,
  output logic              boot_pin_n
);

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  cmd_t cmd;
  logic addressed;

  fcd_decode #(
    .FUNC_W    (FUNC_W),
    .SUB_W     (SUB_W),
    .FUNC_CODE (FUNC_CODE)
  ) u_decode (
    .station_n    (station_n),
    .func_n       (func_n),
    .sub_n        (sub_n),
    .cmd          (cmd),
    .addressed    (addressed),
    .dir_to_logic (dir_to_logic)
  );

  assign x_n = !(addressed && cmd.known);
  assign q_n = x_n;

  // Strobe edge: execute once per strobe assertion
  logic s1_seen_q, s1_seen_d;
  logic fire;

  assign s1_seen_d = !strobe1_n;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) s1_seen_q <= 1'b0;
    else             s1_seen_q <= s1_seen_d;
  end
  assign fire = !strobe1_n && !s1_seen_q && addressed && cmd.known;

  logic [DATA_W-1:0] data_t;
  assign data_t = ~wdata_n;

  logic prog_mode;
  logic sector;

  fcd_ctrl_regs u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .fire       (fire),
    .cmd        (cmd),
    .data_bit0  (data_t[0]),
    .prog_mode  (prog_mode),
    .sector     (sector),
    .boot_pin_n (boot_pin_n)
  );

  logic [ADDR_W-2:0] addr_lo;

  fcd_addr_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SPEC0  (SPEC0),
    .SPEC1  (SPEC1)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .fire       (fire),
    .cmd        (cmd),
    .prog_mode  (prog_mode),
    .data_in    (data_t),
    .addr_lo    (addr_lo),
    .flash_data (flash_data),
    .flash_we_n (flash_we_n)
  );

  assign flash_addr = {sector, addr_lo};

  // R3
  x_needs_station_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !x_n |-> !station_n);

  // R2
  fire_single_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    fire |=> !fire);

endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        station_n = 1'b1;
  logic        strobe1_n = 1'b1;
  logic [4:0]  func_n = 5'b11111;
  logic [3:0]  sub_n = 4'b1111;
  logic [7:0]  wdata_n = 8'hFF;
  logic        dir_to_logic, q_n, x_n, flash_we_n, boot_pin_n;
  logic [18:0] flash_addr;
  logic [7:0]  flash_data;

  always #2 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk (clk), .rst_n (rst_n), .station_n (station_n), .strobe1_n (strobe1_n),
    .func_n (func_n), .sub_n (sub_n), .wdata_n (wdata_n),
    .dir_to_logic (dir_to_logic), .q_n (q_n), .x_n (x_n),
    .flash_addr (flash_addr), .flash_data (flash_data),
    .flash_we_n (flash_we_n), .boot_pin_n (boot_pin_n)
  );

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int we_pulses = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (!flash_we_n) we_pulses <= we_pulses + 1;

  localparam logic [4:0] F19_N = ~5'd19;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic        got_we;
  logic [7:0]  got_data;
  logic [18:0] got_addr_wr;

  // Drive one strobed command; record what the flash sees
  task automatic issue(input logic [3:0] sub, input logic [7:0] dat,
                       input logic [4:0] fn, input bit stat, input int hold);
    @(negedge clk);
    station_n = !stat;
    func_n    = fn;
    sub_n     = ~sub;
    wdata_n   = ~dat;
    @(negedge clk);
    strobe1_n = 1'b0;
    @(negedge clk);
    got_we      = flash_we_n;
    got_data    = flash_data;
    got_addr_wr = flash_addr;
    @(negedge clk);
    repeat (hold) @(negedge clk);
    strobe1_n = 1'b1;
    station_n = 1'b1;
    @(negedge clk);
  endtask

  // {sub[4], data[8], exp_we[1], exp_addr_after[19]}
  localparam int NV = 15;
  localparam logic [31:0] VEC [NV] = '{
    {4'd4,  8'h00, 1'b0, 19'h00000},   // R5 enter mode
    {4'd0,  8'hAA, 1'b1, 19'h05555},   // R7
    {4'd1,  8'h55, 1'b1, 19'h02AAA},   // R7
    {4'd0,  8'hA0, 1'b1, 19'h05555},   // R7
    {4'd3,  8'h11, 1'b1, 19'h00000},   // R8 latch, no increment
    {4'd2,  8'h22, 1'b1, 19'h00001},   // R8 increment and latch
    {4'd2,  8'h33, 1'b1, 19'h00002},   // R8
    {4'd6,  8'h44, 1'b1, 19'h00002},   // R8 increment, keep address
    {4'd12, 8'h00, 1'b0, 19'h00003},   // R9 show counter
    {4'd14, 8'h01, 1'b0, 19'h40003},   // R10 upper half
    {4'd7,  8'h00, 1'b0, 19'h40003},   // R9 clear keeps address
    {4'd12, 8'h00, 1'b0, 19'h40000},   // R9
    {4'd5,  8'h00, 1'b0, 19'h40000},   // R5 leave mode
    {4'd2,  8'h77, 1'b0, 19'h40000},   // R12 ignored
    {4'd14, 8'h00, 1'b0, 19'h00000}    // R10 lower half
  };

  task automatic run_all();
    logic [18:0] prev;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(flash_we_n == 1'b1, "R1 we_n", flash_we_n, 1);
    chk(boot_pin_n == 1'b1, "R1 boot_pin_n", boot_pin_n, 1);
    chk(flash_addr == 19'h0, "R1 addr", flash_addr, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(flash_addr == 19'h0 && flash_we_n, "R1 after release", flash_addr, 0);

    prev = 19'h0;
    for (int i = 0; i < NV; i++) begin
      logic [3:0]  s  = VEC[i][31:28];
      logic [7:0]  d  = VEC[i][27:20];
      logic        ew = VEC[i][19];
      logic [18:0] ea = VEC[i][18:0];
      issue(s, d, F19_N, 1'b1, 0);
      if (ew) begin
        chk(got_we == 1'b0, "R6 strobe", got_we, 0);
        chk(got_data == d, "R6 data", got_data, d);
        chk(got_addr_wr == prev, "R6 write address", got_addr_wr, prev);
      end else begin
        chk(got_we == 1'b1, "R12 no strobe", got_we, 1);
      end
      chk(flash_addr == ea, "R8 address after", flash_addr, ea);
      prev = ea;
    end

    // R3 Q/X responses
    @(negedge clk);
    station_n = 1'b0; func_n = F19_N; sub_n = ~4'd9;
    #1 chk(x_n == 1'b1 && q_n == 1'b1, "R3 unknown sub", x_n, 1);
    sub_n = ~4'd12;
    #1 chk(x_n == 1'b0 && q_n == 1'b0, "R3 known sub", x_n, 0);
    station_n = 1'b1;
    #1 chk(x_n == 1'b1, "R3 not addressed", x_n, 1);
    station_n = 1'b0; func_n = ~5'd17; sub_n = ~4'd4;
    #1 chk(x_n == 1'b1, "R3 wrong function", x_n, 1);
    // R4 direction
    func_n = 5'b11111;
    #1 chk(dir_to_logic == 1'b0, "R4 read", dir_to_logic, 0);
    func_n = 5'b01111;
    #1 chk(dir_to_logic == 1'b1, "R4 write", dir_to_logic, 1);
    func_n = 5'b10111;
    #1 chk(dir_to_logic == 1'b1, "R4 control", dir_to_logic, 1);
    func_n = F19_N;
    #1 chk(dir_to_logic == 1'b1, "R4 f19", dir_to_logic, 1);
    station_n = 1'b1;

    // R2 wrong function and wrong station have no effect
    issue(4'd14, 8'h01, ~5'd17, 1'b1, 0);
    chk(flash_addr[18] == 1'b0, "R2 wrong function", flash_addr[18], 0);
    issue(4'd14, 8'h01, F19_N, 1'b0, 0);
    chk(flash_addr[18] == 1'b0, "R2 wrong station", flash_addr[18], 0);

    // R11 program pin
    issue(4'd15, 8'h01, F19_N, 1'b1, 0);
    chk(boot_pin_n == 1'b0, "R11 pin low", boot_pin_n, 0);
    issue(4'd15, 8'h00, F19_N, 1'b1, 0);
    chk(boot_pin_n == 1'b1, "R11 pin high", boot_pin_n, 1);

    // R2 long strobe executes once; counter 0, latched address 0
    issue(4'd4, 8'h00, F19_N, 1'b1, 0);
    we_pulses = 0;
    issue(4'd2, 8'h5A, F19_N, 1'b1, 6);
    chk(we_pulses == 1, "R2 single strobe", we_pulses, 1);
    chk(flash_addr == 19'h00001, "R2 single increment", flash_addr, 1);
  endtask

  initial begin
    fork
      run_all();
      begin
        wait (cyc >= 20000);
        chk(1'b0, "watchdog", cyc, 0);
      end
    join_any
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule